// File: doc/BRIEF.md
# Dual Switchable Data Pointer Unit

This block holds two 16-bit data pointers and a one-bit select that decides which pointer is active. The active pointer is always presented on `ptr_out`, where it serves as an external memory address or as the base for an indirect jump. The CPU drives a small operation port that can step the active pointer by one or load it with a 16-bit immediate. Only the active pointer is ever touched. The idle pointer keeps its value until software switches back to it.

Software reaches the same storage through the special-function-register byte bus. Two fixed byte addresses map to the low and high halves of the active pointer. A third, parameterised address maps to the select register. Only bit 0 of that register is implemented, and every other bit, bit 2 included, reads back as zero. As a result, a read-add-one-write of the select register flips the active pointer and leaves the other bits at zero.

Top module: `dual_dptr_unit`

## Requirements
- R1: While reset is applied and until it has been released, both pointers and the select bit are zero, so `ptr_out` is 0000h and `ptr_sel` is 0.
- R2: `ptr_sel` (select register bit 0) picks the active pointer: 0 selects pointer 0 and 1 selects pointer 1. `ptr_out` always shows the active pointer.
- R3: `ptr_op` = 2'b10 (load) writes `ptr_imm` into the active pointer at the next clock edge, and the idle pointer is left unchanged.
- R4: `ptr_op` = 2'b01 (step) adds one to the active 16-bit pointer. The carry crosses from the low byte to the high byte in the same cycle, and FFFFh wraps to 0000h.
- R5: With `sfr_addr` = 82h, `sfr_rdata` gives the low byte of the active pointer, and with 83h it gives the high byte. At any address outside the three mapped ones, `sfr_hit` is 0 and `sfr_rdata` is 00h.
- R6: A byte write to 82h replaces only the low byte of the active pointer, and a byte write to 83h replaces only its high byte.
- R7: The select register (default address A2h) reads as 7'b0 followed by the select bit. A write stores `sfr_wdata[0]` only, so bit 2 and all other upper bits read 0 regardless of the value written.
- R8: When a step or load and a byte write to 82h or 83h arrive in the same cycle, the pointer operation decides the new pointer value.
- R9: A step or load issued in the same cycle as a select-register write acts on the pointer that was active before that write. The new selection shows from the next cycle.
- R10: `ptr_op` values 2'b00 and 2'b11 leave both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sfr_addr | input | 8 | SFR byte address |
| sfr_wr | input | 1 | SFR byte write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for the mapped addresses, 00h otherwise |
| sfr_hit | output | 1 | `sfr_addr` matches one of the three mapped addresses |
| ptr_op | input | 2 | Pointer operation: 00 none, 01 step, 10 load, 11 none |
| ptr_imm | input | 16 | Immediate value for a load |
| ptr_out | output | 16 | Active pointer value |
| ptr_sel | output | 1 | Current select bit |

## Verification
The bench steps a pointer across a low-byte carry and across the FFFFh wrap. An adder without the carry would give 1200h instead of 1300h, and a saturating adder would stick at FFFFh. It writes FFh to the select register and then performs a read-add-one-write, so a design that stored upper bits or let bit 2 hold a value would read back a non-zero upper nibble or fail to clear the select bit. It also collides a pointer operation with a byte write and with a select write in the same cycle. A design that let the byte write win, or that acted on the newly chosen pointer, would leave the wrong value in one of the two banks.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  // Operation codes on the CPU pointer port.
  typedef enum logic [1:0] {
    PTR_OP_NONE = 2'b00,
    PTR_OP_STEP = 2'b01,
    PTR_OP_LOAD = 2'b10,
    PTR_OP_RSVD = 2'b11
  } ptr_op_e;

  localparam int unsigned NUM_PTR = 2;

endpackage

// File: rtl/dptr_rst_sync.sv
// Asynchronous assert, synchronous release of the block reset.
module dptr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/dptr_select_reg.sv
// Select register: only bit 0 is stored; every other bit reads as zero.
module dptr_select_reg #(
  parameter int unsigned        DATA_W   = 8,
  parameter int unsigned        ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]  SEL_ADDR = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic              sel,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);

  logic sel_q;
  logic sel_d;
  logic sel_en;

  assign hit    = (sfr_addr == SEL_ADDR);
  assign sel_en = hit && sfr_wr;

  always_comb begin
    sel_d = sel_q;
    if (sel_en) begin
      sel_d = sfr_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  // Bit 2 and the other upper bits are hard-wired to zero.
  assign rdata = {{(DATA_W-1){1'b0}}, sel_q};
  assign sel   = sel_q;

endmodule

// File: rtl/dptr_bank.sv
// One 16-bit pointer with step, load and byte-write paths.
module dptr_bank
  import dptr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  ptr_op_e           op,
  input  logic [PTR_W-1:0]  imm,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             op_step;
  logic             op_load;

  assign op_step = (op == PTR_OP_STEP);
  assign op_load = (op == PTR_OP_LOAD);
  assign ptr_en  = active && (op_step || op_load || wr_lo || wr_hi);

  always_comb begin
    ptr_d = ptr_q;
    if (wr_lo) begin
      ptr_d[DATA_W-1:0] = wdata;
    end
    if (wr_hi) begin
      ptr_d[PTR_W-1:DATA_W] = wdata;
    end
    // Pointer operations take priority over byte writes.
    if (op_step) begin
      ptr_d = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
    end else if (op_load) begin
      ptr_d = imm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h82,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h83,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hA2,
  parameter int unsigned       RST_STAGES = 2,
  localparam int unsigned      PTR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              sfr_hit,
  input  logic [1:0]        ptr_op,
  input  logic [PTR_W-1:0]  ptr_imm,
  output logic [PTR_W-1:0]  ptr_out,
  output logic              ptr_sel
);

  logic              rst_sync_n;
  logic              sel;
  logic              sel_hit;
  logic [DATA_W-1:0] sel_rdata;
  logic              lo_hit;
  logic              hi_hit;
  logic              wr_lo;
  logic              wr_hi;
  ptr_op_e           op;
  logic [PTR_W-1:0]  bank_ptr [NUM_PTR];
  logic [PTR_W-1:0]  act_ptr;

  dptr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dptr_select_reg #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SEL_ADDR (SEL_ADDR)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sel       (sel),
    .hit       (sel_hit),
    .rdata     (sel_rdata)
  );

  assign op     = ptr_op_e'(ptr_op);
  assign lo_hit = (sfr_addr == LO_ADDR);
  assign hi_hit = (sfr_addr == HI_ADDR);
  assign wr_lo  = sfr_wr && lo_hit;
  assign wr_hi  = sfr_wr && hi_hit;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_bank
    dptr_bank #(.DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .active (sel == g[0]),
      .op     (op),
      .imm    (ptr_imm),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wdata  (sfr_wdata),
      .ptr    (bank_ptr[g])
    );
  end

  assign act_ptr = sel ? bank_ptr[1] : bank_ptr[0];

  always_comb begin
    sfr_rdata = '0;
    if (lo_hit) begin
      sfr_rdata = act_ptr[DATA_W-1:0];
    end else if (hi_hit) begin
      sfr_rdata = act_ptr[PTR_W-1:DATA_W];
    end else if (sel_hit) begin
      sfr_rdata = sel_rdata;
    end
  end

  assign sfr_hit = lo_hit || hi_hit || sel_hit;
  assign ptr_out = act_ptr;
  assign ptr_sel = sel;

endmodule

// File: rtl/dual_dptr_unit_chk.sv
module dual_dptr_unit_chk #(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h82,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h83,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hA2,
  localparam int unsigned      PTR_W    = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_wr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic [1:0]        ptr_op,
  input logic [PTR_W-1:0]  ptr_imm,
  input logic [PTR_W-1:0]  ptr_out,
  input logic              ptr_sel
);

  logic sel_wr;
  logic byte_wr;
  logic op_step;
  logic op_load;
  logic op_idle;

  assign sel_wr  = sfr_wr && (sfr_addr == SEL_ADDR);
  assign byte_wr = sfr_wr && ((sfr_addr == LO_ADDR) || (sfr_addr == HI_ADDR));
  assign op_step = (ptr_op == 2'b01);
  assign op_load = (ptr_op == 2'b10);
  assign op_idle = !op_step && !op_load;

  a_r3_load_active: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_load && !sel_wr) |=> (ptr_out == $past(ptr_imm)));

  a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_step && !sel_wr) |=> (ptr_out == PTR_W'($past(ptr_out) + 1'b1)));

  a_r6_low_byte_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sfr_wr && (sfr_addr == LO_ADDR) && op_idle) |=>
      (ptr_out == {$past(ptr_out[PTR_W-1:DATA_W]), $past(sfr_wdata)}));

  a_r7_sel_readback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sfr_addr == SEL_ADDR) |-> (sfr_rdata == {{(DATA_W-1){1'b0}}, ptr_sel}));

  a_r8_op_beats_byte: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_step && byte_wr) |=> (ptr_out == PTR_W'($past(ptr_out) + 1'b1)));

  a_r9_sel_next_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_wr |=> (ptr_sel == $past(sfr_wdata[0])));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_idle && !sfr_wr) |=> $stable(ptr_out));

endmodule

bind dual_dptr_unit dual_dptr_unit_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .LO_ADDR  (LO_ADDR),
  .HI_ADDR  (HI_ADDR),
  .SEL_ADDR (SEL_ADDR)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sfr_addr   (sfr_addr),
  .sfr_wr     (sfr_wr),
  .sfr_wdata  (sfr_wdata),
  .sfr_rdata  (sfr_rdata),
  .ptr_op     (ptr_op),
  .ptr_imm    (ptr_imm),
  .ptr_out    (ptr_out),
  .ptr_sel    (ptr_sel)
);

// File: tb/sim_dual_dptr_unit.sv
`timescale 1ns/1ps
module sim_dual_dptr_unit;

  localparam logic [7:0] A_LO  = 8'h82;
  localparam logic [7:0] A_HI  = 8'h83;
  localparam logic [7:0] A_SEL = 8'hA2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        sfr_hit;
  logic [1:0]  ptr_op = 2'b00;
  logic [15:0] ptr_imm = 16'h0000;
  logic [15:0] ptr_out;
  logic        ptr_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_dptr_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .sfr_hit   (sfr_hit),
    .ptr_op    (ptr_op),
    .ptr_imm   (ptr_imm),
    .ptr_out   (ptr_out),
    .ptr_sel   (ptr_sel)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock of stimulus: drive after a falling edge, clear at the next one.
  task automatic cyc(input logic [1:0] op, input logic [15:0] imm, input logic wr,
                     input logic [7:0] addr, input logic [7:0] wd);
    @(negedge clk);
    ptr_op = op; ptr_imm = imm; sfr_wr = wr; sfr_addr = addr; sfr_wdata = wd;
    @(negedge clk);
    ptr_op = 2'b00; sfr_wr = 1'b0; sfr_addr = 8'h00;
    #0.5;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] data, output logic hit);
    @(negedge clk);
    sfr_addr = addr;
    #1;
    data = sfr_rdata;
    hit  = sfr_hit;
    sfr_addr = 8'h00;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic h;
    #1;
    chk("R1", "ptr_out in reset", ptr_out, 16'h0000);
    chk("R1", "ptr_sel in reset", {15'd0, ptr_sel}, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ptr_out after release", ptr_out, 16'h0000);
    rd(A_SEL, d, h);
    chk("R1", "select read after release", {8'h00, d}, 16'h0000);
  endtask

  task automatic t_load_step();
    cyc(2'b10, 16'h12FF, 1'b0, 8'h00, 8'h00);
    chk("R3", "load 12FF", ptr_out, 16'h12FF);
    cyc(2'b01, 16'h0000, 1'b0, 8'h00, 8'h00);
    chk("R4", "step across low byte carry", ptr_out, 16'h1300);
    cyc(2'b10, 16'hFFFF, 1'b0, 8'h00, 8'h00);
    cyc(2'b01, 16'h0000, 1'b0, 8'h00, 8'h00);
    chk("R4", "step wraps FFFF", ptr_out, 16'h0000);
    cyc(2'b10, 16'h0C0D, 1'b0, 8'h00, 8'h00);
    chk("R3", "load 0C0D", ptr_out, 16'h0C0D);
  endtask

  task automatic t_switch();
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, 8'h01);
    chk("R2", "select set", {15'd0, ptr_sel}, 16'h0001);
    chk("R2", "pointer 1 still reset value", ptr_out, 16'h0000);
    cyc(2'b10, 16'hA55A, 1'b0, 8'h00, 8'h00);
    chk("R3", "load pointer 1", ptr_out, 16'hA55A);
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, 8'h00);
    chk("R3", "pointer 0 kept while idle", ptr_out, 16'h0C0D);
  endtask

  task automatic t_bytes();
    logic [7:0] d; logic h;
    cyc(2'b00, 16'h0000, 1'b1, A_LO, 8'h34);
    chk("R6", "low byte write", ptr_out, 16'h0C34);
    cyc(2'b00, 16'h0000, 1'b1, A_HI, 8'hBE);
    chk("R6", "high byte write", ptr_out, 16'hBE34);
    rd(A_LO, d, h);
    chk("R5", "read low byte", {8'h00, d}, 16'h0034);
    rd(A_HI, d, h);
    chk("R5", "read high byte", {8'h00, d}, 16'h00BE);
    rd(8'h81, d, h);
    chk("R5", "unmapped read data", {8'h00, d}, 16'h0000);
    chk("R5", "unmapped hit", {15'd0, h}, 16'h0000);
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, 8'h01);
    rd(A_LO, d, h);
    chk("R5", "read low byte of pointer 1", {8'h00, d}, 16'h005A);
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, 8'h00);
  endtask

  task automatic t_sel_reg();
    logic [7:0] d; logic h;
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, 8'hFF);
    rd(A_SEL, d, h);
    chk("R7", "write FF reads 01", {8'h00, d}, 16'h0001);
    chk("R7", "select hit", {15'd0, h}, 16'h0001);
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, d + 8'h01);
    rd(A_SEL, d, h);
    chk("R7", "read-add-one toggles to 0", {8'h00, d}, 16'h0000);
    chk("R7", "pointer 0 active again", ptr_out, 16'hBE34);
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, 8'h04);
    rd(A_SEL, d, h);
    chk("R7", "bit 2 not stored", {8'h00, d}, 16'h0000);
  endtask

  task automatic t_collide();
    cyc(2'b01, 16'h0000, 1'b1, A_LO, 8'h00);
    chk("R8", "step beats low write", ptr_out, 16'hBE35);
    cyc(2'b10, 16'h7777, 1'b1, A_HI, 8'h11);
    chk("R8", "load beats high write", ptr_out, 16'h7777);
  endtask

  task automatic t_sel_op();
    cyc(2'b01, 16'h0000, 1'b1, A_SEL, 8'h01);
    chk("R9", "new select visible", {15'd0, ptr_sel}, 16'h0001);
    chk("R9", "pointer 1 untouched", ptr_out, 16'hA55A);
    cyc(2'b00, 16'h0000, 1'b1, A_SEL, 8'h00);
    chk("R9", "old pointer was stepped", ptr_out, 16'h7778);
  endtask

  task automatic t_idle_ops();
    cyc(2'b11, 16'h1234, 1'b0, 8'h00, 8'h00);
    chk("R10", "op 11 holds pointer", ptr_out, 16'h7778);
    cyc(2'b00, 16'h1234, 1'b0, 8'h00, 8'h00);
    chk("R10", "op 00 holds pointer", ptr_out, 16'h7778);
  endtask

  initial begin
    t_reset();
    t_load_step();
    t_switch();
    t_bytes();
    t_sel_reg();
    t_collide();
    t_sel_op();
    t_idle_ops();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule